// File: doc/BRIEF.md
# Readout Result Link Serializer

This block turns readout results from four measurement channels into messages on a two-lane serial message link that feeds a central controller. Each readout produces three messages, always in the same order: a register address, a mask, and then the result data. The address and mask are known when the readout begins, so they are captured on the start pulse and sent while the measurement is still running. The data word follows as soon as the discriminated result arrives, which keeps the latency of the whole exchange short.

Channels 0 and 1 share lane 0, and channels 2 and 3 share lane 1. Each lane sends at most one message per cycle under a valid/ready handshake. When a lane picks its next message, it serves every pending header of its two channels before any data word, and the lower channel goes first. A channel stays busy until its data message has been accepted. A start request that arrives while the channel is busy is refused and reported with a one-cycle error pulse.

Top module: `rr_link_ser`

## Requirements
- R1: A start pulse on an idle channel captures that channel's address and mask. If the lane is free, the address message is presented on the lane in the cycle after the start edge.
- R2: The messages of one readout leave in the order address, mask, data. The message type field encodes address as 2'b01, mask as 2'b10 and data as 2'b11. The payload carries the zero-extended value.
- R3: Channels 0 and 1 use lane 0 and channels 2 and 3 use lane 1. The 2-bit channel field carries the absolute channel number, and a channel's messages never appear on the other lane.
- R4: When a lane picks a new message, all pending headers of its two channels come before any data word. The lower channel wins among headers, and the lower channel also wins among data words.
- R5: Result data that arrives before the channel's own address and mask have been accepted is held. It is sent only after the mask message has been accepted.
- R6: While a lane shows valid and ready is low, the lane keeps valid high and holds type, channel and payload stable, even if a higher-priority message becomes pending. At most one message leaves per accepted handshake.
- R7: If a channel's headers are done and its lane is idle, the data message is presented in the cycle after the result-valid edge, so the latency is a fixed single cycle.
- R8: A start on a busy channel is rejected. The captured address and mask stay unchanged, and the channel's error output pulses high for exactly the one cycle after that edge.
- R9: Acceptance of a channel's data message returns the channel to idle, so a later start is accepted without an error.
- R10: During and straight after reset, no lane shows valid and no error output is high.
- R11: A result-valid pulse on an idle channel, including one in the same cycle as its start, is ignored and never appears as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 4 | Readout start pulse, one bit per channel |
| addr_i | input | 4*AW | Register address per channel, channel c at [c*AW +: AW] |
| mask_i | input | 4*MW | Mask per channel, channel c at [c*MW +: MW] |
| res_valid_i | input | 4 | Discriminated result valid pulse, one bit per channel |
| res_data_i | input | 4*DW | Result data per channel, channel c at [c*DW +: DW] |
| err_o | output | 4 | One-cycle pulse when a start hits a busy channel |
| lane_valid_o | output | 2 | Message valid per lane |
| lane_ready_i | input | 2 | Message ready per lane |
| lane_type_o | output | 4 | Message type per lane, lane l at [2*l +: 2] |
| lane_chan_o | output | 4 | Channel number per lane, lane l at [2*l +: 2] |
| lane_data_o | output | 2*PW | Message payload per lane, lane l at [l*PW +: PW] |

## Verification
The bench starts both channels of one lane together and delivers both results early. It then checks that the two headers of the upper channel still come before the lower channel's data. A design with plain per-channel ordering would send the lower data word too soon, and a design that skipped the header gate would send data ahead of its own mask. In another test a lower channel starts while the lane is stalled on the upper channel's address. A design that re-arbitrates under backpressure would switch the payload in the middle of a handshake. The bench also drives a result in the same cycle as the start and restarts a busy channel with new header values. A wrong design would then send the stray result as data, overwrite the pending address or mask, or miss the error pulse.

// File: rtl/rr_link_ser.sv
module rr_link_ser #(
  parameter int AW = 16,
  parameter int MW = 16,
  parameter int DW = 16,
  localparam int PW = ((AW > MW ? AW : MW) > DW) ? (AW > MW ? AW : MW) : DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      start_i,
  input  logic [4*AW-1:0] addr_i,
  input  logic [4*MW-1:0] mask_i,
  input  logic [3:0]      res_valid_i,
  input  logic [4*DW-1:0] res_data_i,
  output logic [3:0]      err_o,
  output logic [1:0]      lane_valid_o,
  input  logic [1:0]      lane_ready_i,
  output logic [3:0]      lane_type_o,
  output logic [3:0]      lane_chan_o,
  output logic [2*PW-1:0] lane_data_o
);

  localparam int NCH = 4;
  localparam int NL  = NCH / 2;
  localparam logic [1:0] T_ADDR = 2'b01;
  localparam logic [1:0] T_MASK = 2'b10;
  localparam logic [1:0] T_DATA = 2'b11;
  localparam logic [1:0] HDONE  = 2'd2;

  logic [NCH-1:0] busy, dh, hd, hdr, dat, grant;
  logic [1:0]     hst  [NCH];
  logic [PW-1:0]  apay [NCH];
  logic [PW-1:0]  mpay [NCH];
  logic [PW-1:0]  dpay [NCH];

  assign hdr = busy & ~hd;
  assign dat = busy & hd & dh;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          b_q, d_q, e_q;
    logic [1:0]    s_q;
    logic [AW-1:0] a_q;
    logic [MW-1:0] m_q;
    logic [DW-1:0] r_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= 1'b0;
        d_q <= 1'b0;
        e_q <= 1'b0;
        s_q <= 2'd0;
        a_q <= '0;
        m_q <= '0;
        r_q <= '0;
      end else begin
        e_q <= start_i[c] & b_q;
        if (!b_q) begin
          if (start_i[c]) begin
            b_q <= 1'b1;
            d_q <= 1'b0;
            s_q <= 2'd0;
            a_q <= addr_i[c*AW +: AW];
            m_q <= mask_i[c*MW +: MW];
          end
        end else begin
          if (grant[c]) begin
            if (s_q != HDONE) s_q <= s_q + 2'd1;
            else begin
              b_q <= 1'b0;
              d_q <= 1'b0;
            end
          end
          if (res_valid_i[c] && !d_q) begin
            d_q <= 1'b1;
            r_q <= res_data_i[c*DW +: DW];
          end
        end
      end
    end

    assign busy[c]  = b_q;
    assign dh[c]    = d_q;
    assign hd[c]    = (s_q == HDONE);
    assign hst[c]   = s_q;
    assign err_o[c] = e_q;
    assign apay[c]  = PW'(a_q);
    assign mpay[c]  = PW'(m_q);
    assign dpay[c]  = PW'(r_q);
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam int LO = 2 * l;
    localparam int HI = 2 * l + 1;
    logic       lk_q, lks_q, sh, hsel, fire;
    logic [1:0] step;

    assign lane_valid_o[l] = hdr[LO] | hdr[HI] | dat[LO] | dat[HI];
    assign sh   = lk_q ? lks_q : (!hdr[LO] && (hdr[HI] || !dat[LO]));
    assign hsel = sh ? hdr[HI] : hdr[LO];
    assign step = sh ? hst[HI] : hst[LO];
    assign fire = lane_valid_o[l] & lane_ready_i[l];
    assign grant[LO] = fire & ~sh;
    assign grant[HI] = fire & sh;

    assign lane_type_o[2*l +: 2] = !hsel ? T_DATA : (step == 2'd0 ? T_ADDR : T_MASK);
    assign lane_chan_o[2*l +: 2] = 2'(LO) | {1'b0, sh};
    assign lane_data_o[l*PW +: PW] =
      !hsel          ? (sh ? dpay[HI] : dpay[LO]) :
      (step == 2'd0) ? (sh ? apay[HI] : apay[LO]) :
                       (sh ? mpay[HI] : mpay[LO]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_q  <= 1'b0;
        lks_q <= 1'b0;
      end else begin
        lk_q  <= lane_valid_o[l] & ~lane_ready_i[l];
        lks_q <= sh;
      end
    end
  end

endmodule

// File: rtl/rr_link_ser_chk.sv
module rr_link_ser_chk #(
  parameter int PW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      start_i,
  input logic [3:0]      res_valid_i,
  input logic [3:0]      err_o,
  input logic [1:0]      lane_valid_o,
  input logic [1:0]      lane_ready_i,
  input logic [3:0]      lane_type_o,
  input logic [3:0]      lane_chan_o,
  input logic [2*PW-1:0] lane_data_o,
  input logic [3:0]      busy,
  input logic [3:0]      dh
);

  for (genvar l = 0; l < 2; l++) begin : g_l
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid_o[l] && !lane_ready_i[l] |=> lane_valid_o[l]
        && $stable(lane_type_o[2*l +: 2]) && $stable(lane_chan_o[2*l +: 2])
        && $stable(lane_data_o[l*PW +: PW]));
    // R9
    data_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid_o[l] && lane_ready_i[l] && lane_type_o[2*l +: 2] == 2'b11
        |=> !busy[$past(lane_chan_o[2*l +: 2])]);
    // R3
    lane_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid_o[l] |-> busy[lane_chan_o[2*l +: 2]]);
  end

  for (genvar c = 0; c < 4; c++) begin : g_c
    // R8
    busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i[c] && busy[c] |=> err_o[c]);
    // R8
    quiet_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_i[c] && busy[c]) |=> !err_o[c]);
    // R11
    idle_result_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_i[c] && !busy[c] |=> !dh[c]);
  end

endmodule

bind rr_link_ser rr_link_ser_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .res_valid_i(res_valid_i),
  .err_o(err_o), .lane_valid_o(lane_valid_o), .lane_ready_i(lane_ready_i),
  .lane_type_o(lane_type_o), .lane_chan_o(lane_chan_o), .lane_data_o(lane_data_o),
  .busy(busy), .dh(dh)
);

// File: tb/sim_rr_link_ser.sv
module sim_rr_link_ser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  start_i = '0;
  logic [63:0] addr_i = '0;
  logic [63:0] mask_i = '0;
  logic [3:0]  res_valid_i = '0;
  logic [63:0] res_data_i = '0;
  logic [3:0]  err_o;
  logic [1:0]  lane_valid_o;
  logic [1:0]  lane_ready_i = 2'b11;
  logic [3:0]  lane_type_o;
  logic [3:0]  lane_chan_o;
  logic [31:0] lane_data_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rr_link_ser u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic msg(int l, logic v, logic [1:0] t, logic [1:0] ch, logic [15:0] p, string tag);
    chk({tag, " valid"}, 32'(lane_valid_o[l]), 32'(v));
    if (v) begin
      chk({tag, " type"}, 32'(lane_type_o[2*l +: 2]), 32'(t));
      chk({tag, " chan"}, 32'(lane_chan_o[2*l +: 2]), 32'(ch));
      chk({tag, " data"}, 32'(lane_data_o[16*l +: 16]), 32'(p));
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic hdr(int c, logic [15:0] a, logic [15:0] m);
    addr_i[16*c +: 16] = a;
    mask_i[16*c +: 16] = m;
  endtask

  task automatic t_reset();
    chk("R10 valid in reset", 32'(lane_valid_o), 0);
    chk("R10 err in reset", 32'(err_o), 0);
    step();
    rst_n = 1'b1;
    step();
    chk("R10 valid after reset", 32'(lane_valid_o), 0);
    chk("R10 err after reset", 32'(err_o), 0);
  endtask

  task automatic t_single();
    hdr(0, 16'hA000, 16'h00F0);
    start_i = 4'b0001;
    step();
    start_i = '0;
    msg(0, 1, 2'b01, 2'd0, 16'hA000, "R1 R2 address");
    chk("R3 other lane idle", 32'(lane_valid_o[1]), 0);
    step();
    msg(0, 1, 2'b10, 2'd0, 16'h00F0, "R2 mask");
    step();
    msg(0, 0, 0, 0, 0, "R5 no data yet");
    res_valid_i = 4'b0001;
    res_data_i[15:0] = 16'h1234;
    step();
    res_valid_i = '0;
    msg(0, 1, 2'b11, 2'd0, 16'h1234, "R7 data one cycle later");
    step();
    msg(0, 0, 0, 0, 0, "R9 idle after data");
    hdr(0, 16'hA001, 16'h0001);
    start_i = 4'b0001;
    step();
    start_i = '0;
    chk("R9 restart no error", 32'(err_o[0]), 0);
    msg(0, 1, 2'b01, 2'd0, 16'hA001, "R9 restart address");
    step();
    step();
    res_valid_i = 4'b0001;
    res_data_i[15:0] = 16'h0055;
    step();
    res_valid_i = '0;
    msg(0, 1, 2'b11, 2'd0, 16'h0055, "R9 restart data");
    step();
  endtask

  task automatic t_pair();
    hdr(2, 16'hB200, 16'h0F02);
    hdr(3, 16'hB300, 16'h0F03);
    start_i = 4'b1100;
    res_valid_i = 4'b0100;
    res_data_i[47:32] = 16'h0BAD;
    step();
    start_i = '0;
    res_valid_i = 4'b1100;
    res_data_i[47:32] = 16'hD222;
    res_data_i[63:48] = 16'hD333;
    msg(1, 1, 2'b01, 2'd2, 16'hB200, "R4 ch2 address");
    chk("R3 lane0 idle", 32'(lane_valid_o[0]), 0);
    step();
    res_valid_i = '0;
    msg(1, 1, 2'b10, 2'd2, 16'h0F02, "R4 ch2 mask");
    step();
    msg(1, 1, 2'b01, 2'd3, 16'hB300, "R4 R5 ch3 address before ch2 data");
    step();
    msg(1, 1, 2'b10, 2'd3, 16'h0F03, "R4 R5 ch3 mask");
    step();
    msg(1, 1, 2'b11, 2'd2, 16'hD222, "R4 R11 ch2 data");
    step();
    msg(1, 1, 2'b11, 2'd3, 16'hD333, "R4 ch3 data");
    step();
    msg(1, 0, 0, 0, 0, "R4 lane1 drained");
  endtask

  task automatic t_stall();
    lane_ready_i = 2'b10;
    hdr(1, 16'hC100, 16'h0C01);
    start_i = 4'b0010;
    step();
    start_i = '0;
    msg(0, 1, 2'b01, 2'd1, 16'hC100, "R6 ch1 address");
    hdr(0, 16'hC000, 16'h0C00);
    start_i = 4'b0001;
    step();
    start_i = '0;
    msg(0, 1, 2'b01, 2'd1, 16'hC100, "R6 held under stall");
    step();
    msg(0, 1, 2'b01, 2'd1, 16'hC100, "R6 still held");
    lane_ready_i = 2'b11;
    step();
    msg(0, 1, 2'b01, 2'd0, 16'hC000, "R4 R6 ch0 address after release");
    step();
    msg(0, 1, 2'b10, 2'd0, 16'h0C00, "R4 ch0 mask");
    step();
    msg(0, 1, 2'b10, 2'd1, 16'h0C01, "R4 ch1 mask");
    res_valid_i = 4'b0011;
    res_data_i[15:0]  = 16'hDA00;
    res_data_i[31:16] = 16'hDA01;
    step();
    res_valid_i = '0;
    msg(0, 1, 2'b11, 2'd0, 16'hDA00, "R4 ch0 data first");
    step();
    msg(0, 1, 2'b11, 2'd1, 16'hDA01, "R4 ch1 data second");
    step();
    msg(0, 0, 0, 0, 0, "R6 lane0 drained");
  endtask

  task automatic t_error();
    hdr(3, 16'hE300, 16'h0E03);
    start_i = 4'b1000;
    step();
    start_i = '0;
    chk("R8 no error on idle start", 32'(err_o), 0);
    msg(1, 1, 2'b01, 2'd3, 16'hE300, "R8 address");
    hdr(3, 16'hFFFF, 16'hFFFF);
    start_i = 4'b1000;
    step();
    start_i = '0;
    chk("R8 error pulse", 32'(err_o), 32'h8);
    msg(1, 1, 2'b10, 2'd3, 16'h0E03, "R8 mask unchanged");
    step();
    chk("R8 error one cycle", 32'(err_o), 0);
    msg(1, 0, 0, 0, 0, "R8 waiting for data");
    res_valid_i = 4'b1000;
    res_data_i[63:48] = 16'h3E3E;
    step();
    res_valid_i = '0;
    msg(1, 1, 2'b11, 2'd3, 16'h3E3E, "R8 data");
    step();
    msg(1, 0, 0, 0, 0, "R9 ch3 idle");
  endtask

  initial begin
    t_reset();
    t_single();
    t_pair();
    t_stall();
    t_error();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule